// File: doc/BRIEF.md
# Interrupt Controller CPU Interface

This block is the per-processor front end of an interrupt controller. It keeps state for a parameterised set of interrupt sources: an enable bit, a priority value, a security group bit (secure or non-secure) and a trigger mode (level or edge). From this state it drives a registered interrupt request to the processor whenever some pending, enabled, not-active source has a priority value strictly below the programmed mask.

Software reaches it through a small register port. A read of the acknowledge register returns the ID of the best pending source and moves that source to the active state. Under several conditions the read returns a reserved ID and acknowledges nothing: signalling is switched off, no source beats the mask, or the security of the read does not match the group of the winning source. A write to the end-of-interrupt register with the ID of an active source retires it. Lower priority values are more urgent, and ties go to the lower ID.

Top module: `icc_cpu_if`

## Requirements
- R1: An acknowledge read returns the candidate with the smallest priority value. On equal values the lower ID wins. Candidates are pending, enabled and not active. The acknowledge register is read at address 2, and the ID is in bits [9:0] of the read data, which is valid on `reg_rvalid` one cycle after the read.
- R2: Control is at address 0, with bit 0 enabling forwarding and bit 1 enabling signalling, and both are 0 after reset. While either bit is 0, `irq_req` is low and every acknowledge read returns 1023.
- R3: A candidate qualifies only if its priority is strictly less than the mask. The mask is at address 1, bits [PRIO_W-1:0], and is 0 after reset. Priority is written at address 6 with the ID in [9:0] and the value in [16+:PRIO_W]. With no qualifying candidate the read returns 1023 and `irq_req` stays low.
- R4: Configuration is written at address 7 with the ID in [9:0], bit 16 set for non-secure and clear for secure, and bit 17 set for edge and clear for level. After reset every source is secure and level. A secure read (`reg_secure`=1) of a non-secure winner returns 1022. A non-secure read of a secure winner returns 1023.
- R5: A read that returns 1022 or 1023 changes no interrupt state, so a following read of matching security still returns the same winner.
- R6: A successful acknowledge makes the source active from the cycle the response appears. An active source is excluded from `irq_req` and from later reads. An end-of-interrupt write at address 3 with the ID in [9:0] clears the active state of that ID. The write has no effect if that ID is not active.
- R7: A level source whose input falls before acknowledge stops being pending. `irq_req` drops if nothing else qualifies, and a later read returns 1023.
- R8: Enable set is a write at address 4 and enable clear a write at address 5, each with the ID in [9:0]. All sources are disabled after reset. Clearing the enable of a signalled source before the read makes the read return 1023.
- R9: An edge source latches a rising input edge and stays pending after the input falls until it is acknowledged.
- R10: `irq_req` is registered and follows the input through one sampling register: it rises on the second clock edge after a qualifying level input rises.
- R11: A write whose ID is at or above NUM_IRQ changes no source, and an acknowledge read never returns a real ID at or above NUM_IRQ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | NUM_IRQ | Raw interrupt inputs, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_secure | input | 1 | Security of the current access (1 = secure) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read response valid, one cycle after reg_rd |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The hardest situations to reach are the races in which a source is signalled but stops qualifying before the acknowledge read arrives. In one, a level input falls. In the other, software clears its enable. Both paths lead to the reserved ID 1023. The stimulus first waits until `irq_req` has been observed high, then removes the cause with a single input change or register write, and only then issues the read. The security mismatch cases are reached the same way, with a read of the wrong security, and each is followed by a read of the right security to show that the first read left the winner untouched.

// File: rtl/icc_pkg.sv
package icc_pkg;
   localparam int ID_W      = 10;
   localparam int DATA_W    = 32;
   localparam int ADDR_W    = 3;
   localparam int FIRST_RSV = 1020;
   localparam logic [ID_W-1:0] ID_SPUR_NONE  = 10'd1023;
   localparam logic [ID_W-1:0] ID_SPUR_GROUP = 10'd1022;

   typedef enum logic [ADDR_W-1:0] {
      RG_CTRL  = 3'd0,
      RG_MASK  = 3'd1,
      RG_ACK   = 3'd2,
      RG_EOI   = 3'd3,
      RG_ENSET = 3'd4,
      RG_ENCLR = 3'd5,
      RG_PRIO  = 3'd6,
      RG_CFG   = 3'd7
   } icc_reg_e;

   localparam int FLD_VAL_LSB = 16;
   localparam int FLD_GRP_BIT = 16;
   localparam int FLD_EDG_BIT = 17;
endpackage

// File: rtl/icc_regs.sv
module icc_regs
   import icc_pkg::*;
#(
   parameter int NUM_IRQ = 32,
   parameter int PRIO_W  = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic                reg_rd,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic                ctrl_fwd,
   output logic                ctrl_sig,
   output logic [PRIO_W-1:0]   mask,
   output logic                ack_rd,
   output logic [ID_W-1:0]     wr_id,
   output logic                id_ok,
   output logic                en_set,
   output logic                en_clr,
   output logic                prio_we,
   output logic                cfg_we,
   output logic                eoi_we,
   output logic [PRIO_W-1:0]   wr_prio,
   output logic                wr_grp,
   output logic                wr_edge,
   output logic [DATA_W-1:0]   plain_rdata
);
   localparam logic [ID_W:0] LIMIT = (ID_W+1)'(NUM_IRQ);

   icc_reg_e sel;
   assign sel     = icc_reg_e'(reg_addr);
   assign wr_id   = reg_wdata[ID_W-1:0];
   assign id_ok   = {1'b0, wr_id} < LIMIT;
   assign wr_prio = reg_wdata[FLD_VAL_LSB +: PRIO_W];
   assign wr_grp  = reg_wdata[FLD_GRP_BIT];
   assign wr_edge = reg_wdata[FLD_EDG_BIT];

   assign ack_rd  = reg_rd && (sel == RG_ACK);
   assign en_set  = reg_wr && (sel == RG_ENSET);
   assign en_clr  = reg_wr && (sel == RG_ENCLR);
   assign prio_we = reg_wr && (sel == RG_PRIO);
   assign cfg_we  = reg_wr && (sel == RG_CFG);
   assign eoi_we  = reg_wr && (sel == RG_EOI);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_fwd <= 1'b0;
         ctrl_sig <= 1'b0;
         mask     <= '0;
      end else if (reg_wr) begin
         if (sel == RG_CTRL) begin
            ctrl_fwd <= reg_wdata[0];
            ctrl_sig <= reg_wdata[1];
         end
         if (sel == RG_MASK) mask <= reg_wdata[PRIO_W-1:0];
      end
   end

   always_comb begin
      plain_rdata = '0;
      case (sel)
         RG_CTRL: plain_rdata[1:0] = {ctrl_sig, ctrl_fwd};
         RG_MASK: plain_rdata[PRIO_W-1:0] = mask;
         default: plain_rdata = '0;
      endcase
   end

   assert_ctrl_reset_R2: assert property (@(posedge clk)
      !rst_n |=> !ctrl_fwd && !ctrl_sig && mask == '0);
   assert_oob_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (en_set || en_clr) && (wr_id >= ID_W'(NUM_IRQ)) |-> !id_ok);
endmodule

// File: rtl/icc_source.sv
module icc_source
   import icc_pkg::*;
#(
   parameter int PRIO_W = 4,
   parameter int IDX    = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               irq_raw,
   input  logic [ID_W-1:0]    wr_id,
   input  logic               id_ok,
   input  logic               en_set,
   input  logic               en_clr,
   input  logic               prio_we,
   input  logic               cfg_we,
   input  logic               eoi_we,
   input  logic [PRIO_W-1:0]  wr_prio,
   input  logic               wr_grp,
   input  logic               wr_edge,
   input  logic               take,
   output logic               cand,
   output logic [PRIO_W-1:0]  prio,
   output logic               grp
);
   localparam logic [ID_W-1:0] MY_ID = ID_W'(IDX);

   logic in_q, in_qq, edge_mode, enable, active, latch_q;
   logic hit, rise, pending;

   assign hit     = id_ok && (wr_id == MY_ID);
   assign rise    = in_q && !in_qq;
   assign pending = edge_mode ? (latch_q || rise) : in_q;
   assign cand    = pending && enable && !active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_q      <= 1'b0;
         in_qq     <= 1'b0;
         edge_mode <= 1'b0;
         grp       <= 1'b0;
         prio      <= '0;
         enable    <= 1'b0;
         active    <= 1'b0;
         latch_q   <= 1'b0;
      end else begin
         in_q  <= irq_raw;
         in_qq <= in_q;
         if (hit && en_set) enable <= 1'b1;
         if (hit && en_clr) enable <= 1'b0;
         if (hit && prio_we) prio <= wr_prio;
         if (hit && cfg_we) begin
            grp       <= wr_grp;
            edge_mode <= wr_edge;
         end
         if (take)                      active <= 1'b1;
         else if (hit && eoi_we)        active <= 1'b0;
         if (hit && cfg_we)             latch_q <= 1'b0;
         else if (edge_mode)            latch_q <= (latch_q || rise) && !take;
         else                           latch_q <= 1'b0;
      end
   end

   assert_take_is_cand_R6: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> cand);
   assert_active_by_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> $past(take));
   assert_edge_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      edge_mode && latch_q && !take && !(hit && cfg_we) |=> latch_q);
endmodule

// File: rtl/icc_arbiter.sv
module icc_arbiter #(
   parameter int NUM_IRQ = 32,
   parameter int PRIO_W  = 4,
   localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_IRQ-1:0]               cand,
   input  logic [NUM_IRQ-1:0][PRIO_W-1:0]   prio,
   input  logic [NUM_IRQ-1:0]               grp,
   output logic                             found,
   output logic [IDX_W-1:0]                 win_id,
   output logic [PRIO_W-1:0]                win_prio,
   output logic                             win_grp
);
   always_comb begin
      found    = 1'b0;
      win_id   = '0;
      win_prio = '1;
      win_grp  = 1'b0;
      for (int i = 0; i < NUM_IRQ; i++) begin
         if (cand[i] && (!found || prio[i] < win_prio)) begin
            found    = 1'b1;
            win_id   = IDX_W'(i);
            win_prio = prio[i];
            win_grp  = grp[i];
         end
      end
   end

   for (genvar g = 0; g < NUM_IRQ; g++) begin : g_chk
      assert_min_prio_R1: assert property (@(posedge clk) disable iff (!rst_n)
         found && cand[g] |-> prio[g] >= win_prio);
      assert_tie_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
         found && cand[g] && prio[g] == win_prio |-> IDX_W'(g) >= win_id);
   end
endmodule

// File: rtl/icc_cpu_if.sv
module icc_cpu_if
   import icc_pkg::*;
#(
   parameter int NUM_IRQ = 32,
   parameter int PRIO_W  = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_IRQ-1:0]  irq_src,
   input  logic                reg_wr,
   input  logic                reg_rd,
   input  logic                reg_secure,
   input  logic [2:0]          reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   output logic                reg_rvalid,
   output logic                irq_req
);
   localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

   if (NUM_IRQ < 1 || NUM_IRQ > FIRST_RSV) begin : g_bad_count
      $error("NUM_IRQ must lie in 1..1020");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
      $error("PRIO_W must lie in 1..8");
   end

   logic ctrl_fwd, ctrl_sig, ack_rd, id_ok;
   logic en_set, en_clr, prio_we, cfg_we, eoi_we, wr_grp, wr_edge;
   logic [PRIO_W-1:0] mask, wr_prio;
   logic [ID_W-1:0] wr_id;
   logic [DATA_W-1:0] plain_rdata;

   logic [NUM_IRQ-1:0] cand, grp_v, take;
   logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_v;
   logic found, win_grp, hit, grant, rsp_ack;
   logic [IDX_W-1:0] win_id;
   logic [PRIO_W-1:0] win_prio;
   logic [ID_W-1:0] ack_id;

   icc_regs #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .ctrl_fwd(ctrl_fwd), .ctrl_sig(ctrl_sig), .mask(mask), .ack_rd(ack_rd),
      .wr_id(wr_id), .id_ok(id_ok), .en_set(en_set), .en_clr(en_clr),
      .prio_we(prio_we), .cfg_we(cfg_we), .eoi_we(eoi_we),
      .wr_prio(wr_prio), .wr_grp(wr_grp), .wr_edge(wr_edge),
      .plain_rdata(plain_rdata)
   );

   for (genvar g = 0; g < NUM_IRQ; g++) begin : g_src
      icc_source #(.PRIO_W(PRIO_W), .IDX(g)) u_src (
         .clk(clk), .rst_n(rst_n), .irq_raw(irq_src[g]),
         .wr_id(wr_id), .id_ok(id_ok), .en_set(en_set), .en_clr(en_clr),
         .prio_we(prio_we), .cfg_we(cfg_we), .eoi_we(eoi_we),
         .wr_prio(wr_prio), .wr_grp(wr_grp), .wr_edge(wr_edge),
         .take(take[g]), .cand(cand[g]), .prio(prio_v[g]), .grp(grp_v[g])
      );
   end

   icc_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .cand(cand), .prio(prio_v), .grp(grp_v),
      .found(found), .win_id(win_id), .win_prio(win_prio), .win_grp(win_grp)
   );

   // hit: something may be signalled; grant: this read's security matches it
   assign hit   = ctrl_fwd && ctrl_sig && found && (win_prio < mask);
   assign grant = hit && (win_grp != reg_secure);

   always_comb begin
      if (!hit)                   ack_id = ID_SPUR_NONE;
      else if (win_grp && reg_secure) ack_id = ID_SPUR_GROUP;
      else if (!grant)            ack_id = ID_SPUR_NONE;
      else                        ack_id = ID_W'(win_id);
   end

   always_comb begin
      take = '0;
      if (ack_rd && grant) take[win_id] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_rdata  <= '0;
         reg_rvalid <= 1'b0;
         rsp_ack    <= 1'b0;
         irq_req    <= 1'b0;
      end else begin
         reg_rvalid <= reg_rd;
         rsp_ack    <= ack_rd;
         irq_req    <= hit;
         if (reg_rd) reg_rdata <= ack_rd ? DATA_W'(ack_id) : plain_rdata;
      end
   end

   assert_take_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(take));
   assert_sig_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctrl_fwd && ctrl_sig) |=> !irq_req);
   assert_real_id_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ack && reg_rdata[ID_W-1:0] < ID_W'(FIRST_RSV) |-> reg_rdata[ID_W-1:0] < ID_W'(NUM_IRQ));
   assert_spur_no_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ack_rd && !grant |-> take == '0);
   assert_group_1022_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ack_rd && hit && win_grp && reg_secure |=> reg_rdata[ID_W-1:0] == ID_SPUR_GROUP);
endmodule

// File: tb/test_icc_cpu_if.sv
module test_icc_cpu_if;
   localparam int N = 32;
   localparam int A_CTRL = 0, A_MASK = 1, A_ACK = 2, A_EOI = 3;
   localparam int A_ENSET = 4, A_ENCLR = 5, A_PRIO = 6, A_CFG = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] irq_src = '0;
   logic reg_wr = 1'b0, reg_rd = 1'b0, reg_secure = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic reg_rvalid, irq_req;

   int n_cmp = 0;
   int n_bad = 0;
   int exp_q[$];
   string tag_q[$];
   bit done = 1'b0;

   always #4 clk = ~clk;

   icc_cpu_if #(.NUM_IRQ(N), .PRIO_W(4)) i_icc_cpu_if (
      .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_secure(reg_secure), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
      .irq_req(irq_req)
   );

   task automatic check(string tag, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // monitor: compare acknowledge responses against the scoreboard queue
   always @(negedge clk) begin
      if (reg_rvalid) begin
         if (exp_q.size() == 0) check("unexpected response", 1, 0);
         else check(tag_q.pop_front(), int'(reg_rdata[9:0]), exp_q.pop_front());
      end
   end

   task automatic wr(int addr, int data);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 3'(addr); reg_wdata = 32'(data);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic ack(bit sec, int exp, string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = 3'(A_ACK); reg_secure = sec;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cfg(int id, int ns, int edg, int pr);
      wr(A_CFG, id | (ns << 16) | (edg << 17));
      wr(A_PRIO, id | (pr << 16));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++; n_cmp++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      check("R2 request low after reset", int'(irq_req), 0);
      ack(1'b1, 1023, "R2 read with control off");

      wr(A_CTRL, 3);
      wr(A_MASK, 8);
      cfg(5, 1, 0, 3);
      cfg(9, 1, 0, 3);
      cfg(12, 0, 1, 1);
      cfg(8, 1, 0, 2);
      wr(A_ENSET, 5); wr(A_ENSET, 9); wr(A_ENSET, 12);

      // R10 request latency
      @(negedge clk); irq_src[9] = 1'b1;
      @(negedge clk); check("R10 request after one edge", int'(irq_req), 0);
      @(negedge clk); check("R10 request after two edges", int'(irq_req), 1);

      // R1 tie, R6 active handling
      irq_src[5] = 1'b1;
      idle(2);
      ack(1'b0, 5, "R1 tie goes to lower ID");
      check("R6 request held by other source", int'(irq_req), 1);
      ack(1'b0, 9, "R1 second source");
      idle(1);
      check("R6 request drops with all active", int'(irq_req), 0);
      ack(1'b0, 1023, "R6 active sources excluded");
      wr(A_EOI, 7);
      ack(1'b0, 1023, "R6 non-matching end ignored");
      wr(A_EOI, 5);
      ack(1'b0, 5, "R6 end clears active");
      wr(A_EOI, 5); wr(A_EOI, 9);
      irq_src[5] = 1'b0; irq_src[9] = 1'b0;
      idle(3);

      // R3 mask, R9 edge, R4/R5 mismatch
      wr(A_MASK, 1);
      @(negedge clk); irq_src[12] = 1'b1;
      @(negedge clk); irq_src[12] = 1'b0;
      idle(3);
      check("R3 equal priority does not qualify", int'(irq_req), 0);
      ack(1'b1, 1023, "R3 read below mask");
      wr(A_MASK, 2);
      idle(2);
      check("R9 edge held after input fell", int'(irq_req), 1);
      ack(1'b0, 1023, "R4 non-secure read of secure winner");
      ack(1'b1, 12, "R5 winner kept after spurious read");
      wr(A_EOI, 12);
      idle(2);
      check("R9 edge cleared by acknowledge", int'(irq_req), 0);

      wr(A_MASK, 8);
      @(negedge clk); irq_src[5] = 1'b1;
      idle(2);
      ack(1'b1, 1022, "R4 secure read of non-secure winner");
      ack(1'b0, 5, "R5 state unchanged after 1022");
      wr(A_EOI, 5);
      irq_src[5] = 1'b0;
      idle(3);

      // R7 level withdrawn
      irq_src[9] = 1'b1;
      idle(2);
      check("R7 request raised", int'(irq_req), 1);
      irq_src[9] = 1'b0;
      idle(2);
      check("R7 request drops with input", int'(irq_req), 0);
      ack(1'b0, 1023, "R7 late read");

      // R8 enable cleared after signalling
      irq_src[9] = 1'b1;
      idle(2);
      check("R8 request raised", int'(irq_req), 1);
      wr(A_ENCLR, 9);
      ack(1'b0, 1023, "R8 read after enable clear");
      check("R8 request dropped", int'(irq_req), 0);
      wr(A_ENSET, 9);
      ack(1'b0, 9, "R8 re-enabled");
      wr(A_EOI, 9);

      // R2 control bits
      wr(A_CTRL, 1);
      idle(2);
      check("R2 signalling off", int'(irq_req), 0);
      ack(1'b0, 1023, "R2 read with signalling off");
      wr(A_CTRL, 2);
      idle(2);
      check("R2 forwarding off", int'(irq_req), 0);
      ack(1'b0, 1023, "R2 read with forwarding off");
      wr(A_CTRL, 3);
      idle(2);
      check("R2 restored", int'(irq_req), 1);

      // R1 priority order beats ID order
      wr(A_PRIO, 9 | (2 << 16));
      irq_src[5] = 1'b1;
      idle(2);
      ack(1'b0, 9, "R1 lower value wins");
      ack(1'b0, 5, "R1 next best");
      wr(A_EOI, 9); wr(A_EOI, 5);
      irq_src[5] = 1'b0; irq_src[9] = 1'b0;
      idle(3);

      // R11 out-of-range ID must not alias onto source 8
      irq_src[8] = 1'b1;
      wr(A_ENSET, 40);
      idle(2);
      check("R11 request low", int'(irq_req), 0);
      ack(1'b0, 1023, "R11 no aliasing");

      idle(4);
      check("scoreboard drained", exp_q.size(), 0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule